// File: doc/BRIEF.md
# Cascaded Match-Response Gating Controller

This block sits in each device of a daisy-chained set of associative-memory devices and decides, cycle by cycle, whether that device drives or accepts the current bus cycle. A cycle is framed by a synchronous strobe, `cyc`. The active-low chain-hold input is sampled when a cycle opens and becomes the chain's lock state when the cycle closes, so the value presented in one cycle governs the cycle that follows. While the chain is unlocked every device takes part. While it is locked, the response is narrowed to the device holding the highest-priority match, or to the device that owns the first free location.

A device is the highest-priority match when its own match flag is set and no upstream device reports a match. The registered match output ORs the upstream and local flags and feeds the next device. In standard mode, a locked chain answers only through the highest-match device. Enhanced mode relaxes this for writes that do not name the highest-match location, so such writes reach every device. The mode bit follows the same rule as the hold input: it is captured when a cycle opens and takes effect from the next cycle.

Top module: `chain_gate_ctl`

## Requirements
- R1: `hold_n` is captured when a cycle opens, that is on the first clock with `cyc` high. The captured value becomes the lock state when the cycle closes. A 0 locks the chain for the next cycle and a 1 unlocks it for the next cycle.
- R2: While unlocked, a cycle whose target is not next-free asserts `resp_en` in every device, whatever the kind or match state. Kind codes: 0 command write, 1 data write, 2 read. Target codes: 0 other, 1 highest-match, 2 next-free.
- R3: In standard mode while locked, `resp_en` is asserted only when `local_match`=1 and `match_in`=0. This holds for every kind and target.
- R4: In standard mode while locked, a device with `local_match`=0 never responds.
- R5: A cycle with `hold_n`=1 issued while the chain is locked is answered only by the highest-match device. With no such device it has no response, and the following cycle finds the chain unlocked.
- R6: In enhanced mode while locked, a command write (kind 0) or data write (kind 1) with target 0 responds in every device.
- R7: In enhanced mode while locked, a read (kind 2), and any write with target 1, responds only in the highest-match device.
- R8: A next-free cycle (target 2), when unlocked or in enhanced mode, responds only when `full_in`=1 (every upstream device full) and `dev_full`=0.
- R9: `match_out` equals `match_in | local_match` as sampled one clock earlier.
- R10: `resp_en` is registered on the clock that opens a cycle and holds its value through that cycle. It is 0 one clock after any clock with `cyc` low.
- R11: Synchronous reset leaves the chain unlocked and in standard mode, with `resp_en` and `match_out` both 0.
- R12: `enh_mode` is captured when a cycle opens and selects the rules from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc | input | 1 | Cycle strobe, high for the duration of a bus cycle |
| hold_n | input | 1 | Chain hold, 0 requests lock for the next cycle |
| enh_mode | input | 1 | 1 selects enhanced rules from the next cycle |
| cyc_kind | input | 2 | 0 command write, 1 data write, 2 read |
| cyc_tgt | input | 2 | 0 other, 1 highest-match, 2 next-free |
| local_match | input | 1 | This device has a match |
| match_in | input | 1 | Some upstream device has a match |
| full_in | input | 1 | All upstream devices are full |
| dev_full | input | 1 | This device is full |
| resp_en | output | 1 | Device responds to the current cycle |
| match_out | output | 1 | Registered match indication to the next device |

## Verification
The lock and mode state is hidden. It can only be seen through the response of a later cycle, so each swept case is entered through a preparing cycle. That cycle drives the wanted hold and mode values, and the cycle after it carries the stimulus under test. The two-step lag (capture at cycle start, effect after cycle end) gets dedicated sequences. Each sequence shows that a freshly requested lock or mode does not yet act on the cycle that requested it, and that an unlocking cycle issued with no match still yields no response.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
  localparam int KIND_W = 2;
  localparam int TGT_W  = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_CMDWR  = 2'd0,
    KIND_DATAWR = 2'd1,
    KIND_READ   = 2'd2,
    KIND_RSVD   = 2'd3
  } cyc_kind_e;

  typedef enum logic [TGT_W-1:0] {
    TGT_OTHER    = 2'd0,
    TGT_HIGHM    = 2'd1,
    TGT_NEXTFREE = 2'd2,
    TGT_RSVD     = 2'd3
  } cyc_tgt_e;
endpackage

// File: rtl/cgc_strobe_track.sv
module cgc_strobe_track (
  input  logic clk,
  input  logic rst,
  input  logic cyc,
  output logic cyc_q,
  output logic cyc_open,
  output logic cyc_close
);
  always_ff @(posedge clk) begin
    if (rst) cyc_q <= 1'b0;
    else     cyc_q <= cyc;
  end

  assign cyc_open  = cyc & ~cyc_q;
  assign cyc_close = ~cyc & cyc_q;
endmodule

// File: rtl/cgc_lock_state.sv
module cgc_lock_state (
  input  logic clk,
  input  logic rst,
  input  logic cyc_open,
  input  logic cyc_close,
  input  logic hold_n,
  input  logic enh_mode,
  output logic locked,
  output logic enh_q
);
  logic lock_cap;
  logic enh_cap;

  // capture at cycle open
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_cap <= 1'b0;
      enh_cap  <= 1'b0;
    end else if (cyc_open) begin
      lock_cap <= ~hold_n;
      enh_cap  <= enh_mode;
    end
  end

  // apply at cycle close, governs following cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      enh_q  <= 1'b0;
    end else if (cyc_close) begin
      locked <= lock_cap;
      enh_q  <= enh_cap;
    end
  end
endmodule

// File: rtl/cgc_resp_rules.sv
module cgc_resp_rules
  import cgc_pkg::*;
(
  input  logic              locked,
  input  logic              enh,
  input  logic [KIND_W-1:0] kind,
  input  logic [TGT_W-1:0]  tgt,
  input  logic              is_highm,
  input  logic              nf_owner,
  output logic              grant
);
  logic is_nf;
  logic hm_bound;

  assign is_nf    = (tgt == TGT_NEXTFREE);
  assign hm_bound = (kind == KIND_READ) || (kind == KIND_RSVD) || (tgt == TGT_HIGHM);

  always_comb begin
    if (is_nf && (!locked || enh))
      grant = nf_owner;
    else if (!locked)
      grant = 1'b1;
    else if (!enh)
      grant = is_highm;
    else if (hm_bound)
      grant = is_highm;
    else
      grant = 1'b1;
  end
endmodule

// File: rtl/chain_gate_ctl.sv
module chain_gate_ctl
  import cgc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc,
  input  logic              hold_n,
  input  logic              enh_mode,
  input  logic [KIND_W-1:0] cyc_kind,
  input  logic [TGT_W-1:0]  cyc_tgt,
  input  logic              local_match,
  input  logic              match_in,
  input  logic              full_in,
  input  logic              dev_full,
  output logic              resp_en,
  output logic              match_out
);
  logic cyc_q, cyc_open, cyc_close;
  logic locked, enh_q;
  logic grant;

  cgc_strobe_track u_trk (
    .clk(clk), .rst(rst), .cyc(cyc),
    .cyc_q(cyc_q), .cyc_open(cyc_open), .cyc_close(cyc_close)
  );

  cgc_lock_state u_lock (
    .clk(clk), .rst(rst), .cyc_open(cyc_open), .cyc_close(cyc_close),
    .hold_n(hold_n), .enh_mode(enh_mode), .locked(locked), .enh_q(enh_q)
  );

  cgc_resp_rules u_rules (
    .locked(locked), .enh(enh_q), .kind(cyc_kind), .tgt(cyc_tgt),
    .is_highm(local_match & ~match_in),
    .nf_owner(full_in & ~dev_full),
    .grant(grant)
  );

  always_ff @(posedge clk) begin
    if (rst)           resp_en <= 1'b0;
    else if (cyc_open) resp_en <= grant;
    else if (!cyc)     resp_en <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) match_out <= 1'b0;
    else     match_out <= match_in | local_match;
  end
endmodule

// File: rtl/cgc_chk.sv
module cgc_chk (
  input logic       clk,
  input logic       rst,
  input logic       cyc,
  input logic       cyc_q,
  input logic       locked,
  input logic       enh_q,
  input logic [1:0] cyc_kind,
  input logic [1:0] cyc_tgt,
  input logic       local_match,
  input logic       match_in,
  input logic       full_in,
  input logic       dev_full,
  input logic       resp_en,
  input logic       match_out
);
  // R9
  match_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> match_out == ($past(match_in) | $past(local_match)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc |=> !resp_en);

  // R10
  held_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc && cyc_q) |=> $stable(resp_en));

  // R3
  std_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc && !cyc_q && locked && !enh_q) |=> resp_en == ($past(local_match) && !$past(match_in)));

  // R4
  std_nomatch_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc && !cyc_q && locked && !enh_q && !local_match) |=> !resp_en);

  // R8
  next_free_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc && !cyc_q && cyc_tgt == 2'd2 && (!locked || enh_q)) |=> resp_en == ($past(full_in) && !$past(dev_full)));

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!locked && !enh_q && !resp_en && !match_out));
endmodule

bind chain_gate_ctl cgc_chk u_chk (
  .clk(clk), .rst(rst), .cyc(cyc), .cyc_q(cyc_q), .locked(locked), .enh_q(enh_q),
  .cyc_kind(cyc_kind), .cyc_tgt(cyc_tgt), .local_match(local_match),
  .match_in(match_in), .full_in(full_in), .dev_full(dev_full),
  .resp_en(resp_en), .match_out(match_out)
);

// File: tb/tb_chain_gate_ctl.sv
`timescale 1ns/1ps
module tb_chain_gate_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc = 1'b0, hold_n = 1'b1, enh_mode = 1'b0;
  logic [1:0] cyc_kind = 2'd0, cyc_tgt = 2'd0;
  logic local_match = 1'b0, match_in = 1'b0, full_in = 1'b0, dev_full = 1'b0;
  logic resp_en, match_out;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chain_gate_ctl dut (
    .clk(clk), .rst(rst), .cyc(cyc), .hold_n(hold_n), .enh_mode(enh_mode),
    .cyc_kind(cyc_kind), .cyc_tgt(cyc_tgt), .local_match(local_match),
    .match_in(match_in), .full_in(full_in), .dev_full(dev_full),
    .resp_en(resp_en), .match_out(match_out)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // one full cycle; returns response inside cycle, match_out, response after
  task automatic run_cyc(input bit h, input bit e, input int k, input int t,
                         input bit lm, input bit mi, input bit fi, input bit df,
                         output logic r, output logic mo, output logic ra);
    @(negedge clk);
    cyc = 1'b1; hold_n = h; enh_mode = e; cyc_kind = 2'(k); cyc_tgt = 2'(t);
    local_match = lm; match_in = mi; full_in = fi; dev_full = df;
    @(negedge clk);
    r = resp_en; mo = match_out;
    cyc = 1'b0;
    @(negedge clk);
    ra = resp_en;
  endtask

  function automatic bit model(bit md, bit lk, int k, int t, bit lm, bit mi, bit fi, bit df);
    bit hm = lm && !mi;
    if (t == 2 && (!lk || md)) return fi && !df;
    if (!lk) return 1'b1;
    if (!md) return hm;
    if (k == 2 || t == 1) return hm;
    return 1'b1;
  endfunction

  function automatic string tag_of(bit md, bit lk, int k, int t, bit lm);
    if (t == 2 && (!lk || md)) return "R8";
    if (!lk) return "R2";
    if (!md) return lm ? "R3" : "R4";
    if (k == 2 || t == 1) return "R7";
    return "R6";
  endfunction

  task automatic do_reset();
    rst = 1'b1; cyc = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic r, mo, ra;
    do_reset();
    @(negedge clk);
    check("R11 resp after reset", resp_en, 1'b0);
    check("R11 match_out after reset", match_out, 1'b0);
    // unlocked after reset: read with no match still responds
    run_cyc(0, 0, 2, 0, 0, 0, 0, 0, r, mo, ra);
    check("R11 unlocked after reset", r, 1'b1);
    // R1: lock requested above now in effect
    run_cyc(1, 0, 2, 0, 0, 0, 0, 0, r, mo, ra);
    check("R1 lock applies next cycle", r, 1'b0);
    // R5: unlock cycle above had no match; chain is now unlocked
    run_cyc(0, 0, 2, 0, 0, 0, 0, 0, r, mo, ra);
    check("R5 unlocked after unlock cycle", r, 1'b1);
    // locked now; unlock cycle with highest match responds
    run_cyc(1, 0, 2, 0, 1, 0, 0, 0, r, mo, ra);
    check("R5 unlock acts on highest match", r, 1'b1);
    run_cyc(0, 0, 2, 0, 1, 1, 0, 0, r, mo, ra);
    check("R1 unlock applies next cycle", r, 1'b1);
    // R12: mode request not effective within its own cycle
    do_reset();
    run_cyc(0, 0, 0, 0, 0, 0, 0, 0, r, mo, ra);
    run_cyc(0, 1, 1, 0, 0, 0, 0, 0, r, mo, ra);
    check("R12 mode not yet applied", r, 1'b0);
    run_cyc(0, 1, 1, 0, 0, 0, 0, 0, r, mo, ra);
    check("R12 mode applied next cycle", r, 1'b1);
    check("R10 low after cycle", ra, 1'b0);

    // sweep: prepare state, then test cycle
    for (int md = 0; md < 2; md++)
      for (int lk = 0; lk < 2; lk++)
        for (int k = 0; k < 3; k++)
          for (int t = 0; t < 3; t++)
            for (int v = 0; v < 16; v++) begin
              bit lm = v[0], mi = v[1], fi = v[2], df = v[3];
              run_cyc(!lk, md[0], 0, 0, 0, 0, 0, 0, r, mo, ra);
              run_cyc(1, md[0], k, t, lm, mi, fi, df, r, mo, ra);
              check(tag_of(md[0], lk[0], k, t, lm), r, model(md[0], lk[0], k, t, lm, mi, fi, df));
              check("R9 match_out", mo, lm | mi);
              check("R10 resp cleared", ra, 1'b0);
            end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule